// File: doc/BRIEF.md
# Multiprocessor-Format Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single input line. It samples the line on a 16x oversampling tick and places each complete data byte in a holding register. It reports framing, parity and overrun conditions, and it raises two interrupt requests: one for data ready and one for errors. Both requests are gated by an enable. A pin-select output gives the line back to general-purpose I/O whenever reception is switched off.

In multiprocessor format the bit after the data bits marks a frame as an address (1) or as data (0). Software arms a wake-up filter with a one-cycle strobe. While the filter is armed and active, data frames are thrown away. They load nothing, set no status flag and raise no interrupt. The first address frame is accepted as a normal frame, and the hardware then disarms the filter by itself. Control and status are plain ports. The holding register and the flags are held in the block, and each flag has its own clear strobe.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is a 0 start bit, then 8 data bits sent LSB first, then an optional extra bit, then a 1 stop bit. Each bit lasts 16 sample ticks. When a frame completes while the data-ready flag is 0, its data bits appear on `rx_data` and `rdrf` goes to 1.
- R2: A low level on `rxd` counts as a start bit only if the line is still 0 at the middle of the start bit. A shorter low pulse produces no frame.
- R3: While `rx_irq_en` is 1, `rxi` follows `rdrf` and `eri` follows the OR of `orer`, `fer` and `per`. While `rx_irq_en` is 0, both are 0. All flags and outputs reset to 0.
- R4: `rxd_is_gpio` is the inverse of `rx_en`. Dropping `rx_en` partway through a frame aborts that frame and sets no flag. Nothing is received while `rx_en` is 0.
- R5: An accepted frame whose stop bit samples 0 sets `fer` and still loads its data.
- R6: When `par_en` is 1 and `mp_fmt` is 0, the extra bit is a parity bit. With `par_odd`=0 the data bits plus parity must hold an even number of ones. With `par_odd`=1 they must hold an odd number. A mismatch sets `per`.
- R7: A frame that completes while `rdrf` is 1 sets `orer`. It leaves `rx_data`, `rdrf`, `fer` and `per` unchanged.
- R8: When `mp_fmt` is 1, the extra bit is the multiprocessor bit. While `mp_wait` is 1 and `sync_mode` is 0, a frame whose multiprocessor bit is 0 changes neither `rx_data` nor any flag.
- R9: While the filter is active, `rxi` and `eri` stay 0. A frame whose multiprocessor bit is 1 is accepted as in R1, R5 and R7, and it clears `mp_wait`. A one-cycle `mp_arm` pulse sets `mp_wait`.
- R10: When `mp_fmt` is 0 or `sync_mode` is 1, `mp_wait` has no effect. Every frame is accepted and `mp_wait` keeps its value.
- R11: A pulse on `clr_rdrf`, `clr_orer`, `clr_fer` or `clr_per` clears that one flag. Otherwise a set flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line |
| sample_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_en | input | 1 | Receive enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| mp_fmt | input | 1 | Multiprocessor format select |
| sync_mode | input | 1 | Synchronous mode select (disables the filter) |
| par_en | input | 1 | Parity bit present (non-multiprocessor format) |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| mp_arm | input | 1 | One-cycle strobe that arms the wake-up filter |
| clr_rdrf | input | 1 | Clear strobe for rdrf |
| clr_orer | input | 1 | Clear strobe for orer |
| clr_fer | input | 1 | Clear strobe for fer |
| clr_per | input | 1 | Clear strobe for per |
| rx_data | output | DATA_W | Received data holding register |
| rdrf | output | 1 | Data-ready flag |
| orer | output | 1 | Overrun flag |
| fer | output | 1 | Framing-error flag |
| per | output | 1 | Parity-error flag |
| mp_wait | output | 1 | Wake-up filter armed |
| rxi | output | 1 | Data-ready interrupt request |
| eri | output | 1 | Error interrupt request |
| rxd_is_gpio | output | 1 | 1 = line released to general-purpose I/O |

## Verification
The case that is hardest to reach from the ports is a filtered frame arriving while the flags already hold values. The stimulus first fills the data register and then arms the filter. It sends a data frame carrying a stop-bit error, and then checks that `rx_data`, every flag and both interrupts are unchanged. Next it clears the flags and sends an address frame, which must load data and disarm the filter. An abort is produced by dropping `rx_en` after three data bits and holding the line idle before enabling again, so that no leftover bit can look like a new start bit.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_EXTRA,
      ST_STOP
   } rx_state_e;

   function automatic logic parity_mismatch(input logic ones_odd, input logic pbit,
                                            input logic want_odd);
      return (ones_odd ^ pbit) != want_odd;
   endfunction
endpackage

// File: rtl/mpr_frame_rx.sv
module mpr_frame_rx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              tick,
   input  logic              rxd,
   input  logic              extra_en,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              extra_bit,
   output logic              stop_bit
);
   import mpr_pkg::*;

   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);
   localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

   rx_state_e      state;
   logic [CW-1:0]  cnt;
   logic [BW-1:0]  nbits;
   logic [1:0]     sync_q;
   logic           rxs;

   assign rxs = sync_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], rxd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         nbits     <= '0;
         data      <= '0;
         extra_bit <= 1'b0;
         stop_bit  <= 1'b1;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!rx_en) begin
            state <= ST_IDLE;
            cnt   <= '0;
            nbits <= '0;
         end else if (tick) begin
            case (state)
               ST_IDLE: begin
                  cnt <= '0;
                  if (!rxs) state <= ST_START;
               end
               ST_START: begin
                  if (cnt == MID) begin
                     cnt   <= '0;
                     nbits <= '0;
                     state <= rxs ? ST_IDLE : ST_DATA;
                  end else cnt <= cnt + 1'b1;
               end
               ST_DATA: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     data  <= {rxs, data[DATA_W-1:1]};
                     nbits <= nbits + 1'b1;
                     if (nbits == BLAST) state <= extra_en ? ST_EXTRA : ST_STOP;
                  end else cnt <= cnt + 1'b1;
               end
               ST_EXTRA: begin
                  if (cnt == LAST) begin
                     cnt       <= '0;
                     extra_bit <= rxs;
                     state     <= ST_STOP;
                  end else cnt <= cnt + 1'b1;
               end
               ST_STOP: begin
                  if (cnt == LAST) begin
                     cnt      <= '0;
                     stop_bit <= rxs;
                     done     <= 1'b1;
                     state    <= ST_IDLE;
                  end else cnt <= cnt + 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mpr_status.sv
module mpr_status #(
   parameter int DATA_W      = 8,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] data,
   input  logic              extra_bit,
   input  logic              stop_bit,
   input  logic              mp_fmt,
   input  logic              sync_mode,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              mp_arm,
   input  logic              clr_rdrf,
   input  logic              clr_orer,
   input  logic              clr_fer,
   input  logic              clr_per,
   output logic [DATA_W-1:0] rdr,
   output logic              rdrf,
   output logic              orer,
   output logic              fer,
   output logic              per,
   output logic              mpie,
   output logic              filt_active
);
   import mpr_pkg::*;

   logic par_bad, accept, load, overrun;

   generate
      if (PAR_SUPPORT) begin : g_par
         assign par_bad = par_en & ~mp_fmt & parity_mismatch(^data, extra_bit, par_odd);
      end else begin : g_nopar
         assign par_bad = 1'b0;
      end
   endgenerate

   assign filt_active = mpie & mp_fmt & ~sync_mode;
   assign accept      = done & ~(filt_active & ~extra_bit);
   assign load        = accept & ~rdrf;
   assign overrun     = accept & rdrf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdr  <= '0;
         rdrf <= 1'b0;
         orer <= 1'b0;
         fer  <= 1'b0;
         per  <= 1'b0;
         mpie <= 1'b0;
      end else begin
         if (load) rdr <= data;

         if (load)          rdrf <= 1'b1;
         else if (clr_rdrf) rdrf <= 1'b0;

         if (overrun)       orer <= 1'b1;
         else if (clr_orer) orer <= 1'b0;

         if (load && !stop_bit) fer <= 1'b1;
         else if (clr_fer)      fer <= 1'b0;

         if (load && par_bad) per <= 1'b1;
         else if (clr_per)    per <= 1'b0;

         if (mp_arm)                      mpie <= 1'b1;
         else if (accept && filt_active)  mpie <= 1'b0;
      end
   end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              sample_tick,
   input  logic              rx_en,
   input  logic              rx_irq_en,
   input  logic              mp_fmt,
   input  logic              sync_mode,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              mp_arm,
   input  logic              clr_rdrf,
   input  logic              clr_orer,
   input  logic              clr_fer,
   input  logic              clr_per,
   output logic [DATA_W-1:0] rx_data,
   output logic              rdrf,
   output logic              orer,
   output logic              fer,
   output logic              per,
   output logic              mp_wait,
   output logic              rxi,
   output logic              eri,
   output logic              rxd_is_gpio
);
   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("DATA_W must lie in 5..16");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
   endgenerate

   logic              f_done, f_extra, f_stop, extra_en, filt;
   logic [DATA_W-1:0] f_data;

   assign extra_en = mp_fmt | (par_en & PAR_SUPPORT);

   mpr_frame_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(sample_tick), .rxd(rxd),
      .extra_en(extra_en), .done(f_done), .data(f_data),
      .extra_bit(f_extra), .stop_bit(f_stop)
   );

   mpr_status #(.DATA_W(DATA_W), .PAR_SUPPORT(PAR_SUPPORT)) u_status (
      .clk(clk), .rst_n(rst_n), .done(f_done), .data(f_data),
      .extra_bit(f_extra), .stop_bit(f_stop), .mp_fmt(mp_fmt),
      .sync_mode(sync_mode), .par_en(par_en), .par_odd(par_odd),
      .mp_arm(mp_arm), .clr_rdrf(clr_rdrf), .clr_orer(clr_orer),
      .clr_fer(clr_fer), .clr_per(clr_per), .rdr(rx_data), .rdrf(rdrf),
      .orer(orer), .fer(fer), .per(per), .mpie(mp_wait), .filt_active(filt)
   );

   assign rxi         = rx_irq_en & ~filt & rdrf;
   assign eri         = rx_irq_en & ~filt & (orer | fer | per);
   assign rxd_is_gpio = ~rx_en;
endmodule

// File: rtl/mpr_rx_checker.sv
module mpr_rx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              rx_irq_en,
   input logic              mp_fmt,
   input logic              sync_mode,
   input logic              clr_rdrf,
   input logic [DATA_W-1:0] rx_data,
   input logic              rdrf,
   input logic              orer,
   input logic              fer,
   input logic              per,
   input logic              mp_wait,
   input logic              rxi,
   input logic              eri
);
   p_irq_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_irq_en |-> (!rxi && !eri));

   p_eri_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eri |-> (orer || fer || per));

   p_rxi_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rxi |-> rdrf);

   p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !$past(rx_en)) |-> !$rose(rdrf));

   p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(orer) |-> ($stable(rx_data) && !$rose(rdrf)));

   p_filter_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mp_wait && mp_fmt && !sync_mode) |-> (!rxi && !eri));

   p_wake_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mp_wait) |-> (rdrf || orer));

   p_rdrf_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rdrf && !clr_rdrf) |=> rdrf);
endmodule

bind mp_uart_rx mpr_rx_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_irq_en(rx_irq_en),
   .mp_fmt(mp_fmt), .sync_mode(sync_mode), .clr_rdrf(clr_rdrf),
   .rx_data(rx_data), .rdrf(rdrf), .orer(orer), .fer(fer), .per(per),
   .mp_wait(mp_wait), .rxi(rxi), .eri(eri)
);

// File: tb/mp_uart_rx_test.sv
`timescale 1ns/1ps
module mp_uart_rx_test;
   localparam int BITCLK = 32;

   logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, sample_tick = 1'b0;
   logic rx_en = 0, rx_irq_en = 0, mp_fmt = 0, sync_mode = 0, par_en = 0, par_odd = 0;
   logic mp_arm = 0, clr_rdrf = 0, clr_orer = 0, clr_fer = 0, clr_per = 0;
   logic [7:0] rx_data;
   logic rdrf, orer, fer, per, mp_wait, rxi, eri, rxd_is_gpio;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;
   always @(posedge clk) sample_tick <= ~sample_tick;

   mp_uart_rx uut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .sample_tick(sample_tick),
      .rx_en(rx_en), .rx_irq_en(rx_irq_en), .mp_fmt(mp_fmt), .sync_mode(sync_mode),
      .par_en(par_en), .par_odd(par_odd), .mp_arm(mp_arm), .clr_rdrf(clr_rdrf),
      .clr_orer(clr_orer), .clr_fer(clr_fer), .clr_per(clr_per),
      .rx_data(rx_data), .rdrf(rdrf), .orer(orer), .fer(fer), .per(per),
      .mp_wait(mp_wait), .rxi(rxi), .eri(eri), .rxd_is_gpio(rxd_is_gpio)
   );

   typedef struct {
      logic [7:0] data;
      logic rdrf, orer, fer, per, mpw, rxi, eri, gpio;
      string tag;
   } exp_t;

   exp_t q[$];
   event chk_ev;

   logic [7:0] e_data = 0;
   logic e_rdrf = 0, e_orer = 0, e_fer = 0, e_per = 0, e_mpw = 0;

   task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            e = q.pop_front();
            cmp(e.tag, "rx_data", rx_data, e.data);
            cmp(e.tag, "rdrf", {7'd0, rdrf}, {7'd0, e.rdrf});
            cmp(e.tag, "orer", {7'd0, orer}, {7'd0, e.orer});
            cmp(e.tag, "fer", {7'd0, fer}, {7'd0, e.fer});
            cmp(e.tag, "per", {7'd0, per}, {7'd0, e.per});
            cmp(e.tag, "mp_wait", {7'd0, mp_wait}, {7'd0, e.mpw});
            cmp(e.tag, "rxi", {7'd0, rxi}, {7'd0, e.rxi});
            cmp(e.tag, "eri", {7'd0, eri}, {7'd0, e.eri});
            cmp(e.tag, "rxd_is_gpio", {7'd0, rxd_is_gpio}, {7'd0, e.gpio});
         end
      end
   end

   task automatic expect_now(string tag);
      exp_t e;
      logic f;
      f = e_mpw & mp_fmt & ~sync_mode;
      e.data = e_data; e.rdrf = e_rdrf; e.orer = e_orer; e.fer = e_fer;
      e.per = e_per; e.mpw = e_mpw; e.gpio = ~rx_en;
      e.rxi = rx_irq_en & ~f & e_rdrf;
      e.eri = rx_irq_en & ~f & (e_orer | e_fer | e_per);
      e.tag = tag;
      q.push_back(e);
      -> chk_ev;
      @(negedge clk);
   endtask

   task automatic hold_bit(logic v);
      rxd = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic send_frame(logic [7:0] d, logic xbit, logic stopv, string tag);
      logic f, has_x, pbad;
      has_x = mp_fmt | par_en;
      hold_bit(1'b0);
      for (int i = 0; i < 8; i++) hold_bit(d[i]);
      if (has_x) hold_bit(xbit);
      hold_bit(stopv);
      rxd = 1'b1;
      repeat (16) @(negedge clk);
      f = e_mpw & mp_fmt & ~sync_mode;
      pbad = par_en & ~mp_fmt & (((^d) ^ xbit) != par_odd);
      if (!(f && !xbit)) begin
         if (f) e_mpw = 1'b0;
         if (e_rdrf) e_orer = 1'b1;
         else begin
            e_data = d; e_rdrf = 1'b1;
            if (!stopv) e_fer = 1'b1;
            if (pbad) e_per = 1'b1;
         end
      end
      expect_now(tag);
   endtask

   task automatic clear_all();
      clr_rdrf = 1; clr_orer = 1; clr_fer = 1; clr_per = 1;
      @(negedge clk);
      clr_rdrf = 0; clr_orer = 0; clr_fer = 0; clr_per = 0;
      e_rdrf = 0; e_orer = 0; e_fer = 0; e_per = 0;
   endtask

   task automatic arm();
      mp_arm = 1; @(negedge clk); mp_arm = 0;
      e_mpw = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : driver
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_now("R3 reset");

      rx_en = 1; rx_irq_en = 1;
      @(negedge clk);
      expect_now("R4 enabled pin");
      send_frame(8'hA5, 1'b0, 1'b1, "R1 basic frame");
      send_frame(8'h3C, 1'b0, 1'b1, "R7 overrun");
      clr_orer = 1; @(negedge clk); clr_orer = 0; e_orer = 0;
      expect_now("R11 clear orer only");
      clear_all();
      expect_now("R11 clear all");

      send_frame(8'h5A, 1'b0, 1'b0, "R5 framing error");
      clear_all();

      rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
      repeat (400) @(negedge clk);
      expect_now("R2 short glitch");

      par_en = 1; par_odd = 0;
      send_frame(8'h07, 1'b0, 1'b1, "R6 even parity bad");
      clear_all();
      send_frame(8'h07, 1'b1, 1'b1, "R6 even parity good");
      clear_all();
      par_odd = 1;
      send_frame(8'h0F, 1'b1, 1'b1, "R6 odd parity good");
      clear_all();
      send_frame(8'h0F, 1'b0, 1'b1, "R6 odd parity bad");
      clear_all();
      par_en = 0; par_odd = 0;

      rx_irq_en = 0;
      send_frame(8'h11, 1'b0, 1'b0, "R3 irq disabled");
      rx_irq_en = 1;
      expect_now("R3 irq reenabled");
      clear_all();

      hold_bit(1'b0);
      for (int i = 0; i < 3; i++) hold_bit(1'b0);
      rx_en = 0; rxd = 1'b1;
      repeat (4) @(negedge clk);
      expect_now("R4 disabled mid frame");
      repeat (50) @(negedge clk);
      rx_en = 1;
      repeat (400) @(negedge clk);
      expect_now("R4 aborted frame no flags");

      mp_fmt = 1;
      send_frame(8'h42, 1'b0, 1'b1, "R8 unfiltered mp data");
      arm();
      expect_now("R9 filter masks rxi");
      send_frame(8'h99, 1'b0, 1'b0, "R8 filtered with flags held");
      clear_all();
      send_frame(8'h77, 1'b0, 1'b1, "R8 filtered frame discarded");
      send_frame(8'h81, 1'b1, 1'b1, "R9 wake frame");
      clear_all();

      mp_fmt = 0;
      arm();
      send_frame(8'h24, 1'b0, 1'b1, "R10 mp format off");
      clear_all();
      mp_fmt = 1; sync_mode = 1;
      send_frame(8'h6B, 1'b0, 1'b1, "R10 sync mode set");
      sync_mode = 0;
      expect_now("R9 filter active again");
      clear_all();
      send_frame(8'hC3, 1'b1, 1'b1, "R9 second wake");

      rx_en = 0;
      @(negedge clk);
      send_frame_off();
      repeat (4) @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic send_frame_off();
      hold_bit(1'b0);
      for (int i = 0; i < 9; i++) hold_bit(1'b0);
      hold_bit(1'b1);
      repeat (16) @(negedge clk);
      expect_now("R4 no reception while off");
   endtask
endmodule